// File: doc/BRIEF.md
# Dual ADC Shared-Strobe Read Sequencer

This block is a host-side controller for two serial analog-to-digital converters. The two converters share one convert strobe, one serial clock and one data line. Each converter has its own active-low select and drives the data line only while it is selected. A single start request raises the shared convert strobe with both selects held high, so both converters begin a conversion at the same moment.

The controller then waits a fixed worst-case conversion time, counted in system clock cycles. It keeps both selects high for that whole window so that neither converter signals busy. It then selects converter 0 and reads 18 bits, most significant bit first. Both selects go high for one cycle, and it reads converter 1 the same way. Each bit is sampled as the serial clock falls. When the second read ends, the strobe drops, both words appear together on the parallel outputs, and a one-cycle done pulse marks them.

The serial clock half-period and the conversion wait are parameters. The number of converters and the word width are fixed at two and 18.

Top module: `adc_cs_read_seq`

## Requirements
- R1: After reset the convert strobe is low, both selects are high, the serial clock is low, done is low and both result words are zero.
- R2: A start seen while idle raises the convert strobe on the next clock edge with both selects high. The strobe stays high until the last bit of converter 1 has been taken, and it is high whenever any select is low.
- R3: The first select goes low exactly CONV_CYCLES clock cycles after the convert strobe rises. Until then both selects stay high.
- R4: Converter 0 (select bit 0) is read before converter 1 (select bit 1). The two selects are never low together, and both are high for at least one cycle between the two reads.
- R5: While a converter is selected, the serial clock rests low and then makes exactly 18 falling edges. Its high and low phases each last SCK_DIV clock cycles. The clock is low whenever no converter is selected.
- R6: The data line is sampled at each serial clock falling edge, and the first bit taken is the most significant. The word from converter 0 appears on result0 and the word from converter 1 appears on result1, each as an 18-bit value with bit 17 first on the line.
- R7: On the clock edge after the 18th falling edge of converter 1, done pulses high for exactly one cycle, both results update together, and the convert strobe goes low. Results hold their value until the next done pulse.
- R8: A start raised while a conversion or read is in progress has no effect: it neither restarts the wait nor causes an extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to convert and read both converters |
| sdo_i | input | 1 | Shared serial data line from the converters |
| cnv_o | output | 1 | Shared convert strobe |
| sck_o | output | 1 | Shared serial clock |
| cs_n_o | output | 2 | Active-low selects, bit 0 for converter 0 and bit 1 for converter 1 |
| result0_o | output | 18 | Last word read from converter 0 |
| result1_o | output | 18 | Last word read from converter 1 |
| done_o | output | 1 | One-cycle pulse when both results are new |

## Verification
The bench builds the block with CONV_CYCLES = 12 and SCK_DIV = 2. With these values one full sequence takes under 170 cycles, so the bench can cover many data patterns, mid-run starts and exact counts of the wait window and of clock edges. SCK_DIV = 2 gives a half-period longer than one cycle, which exposes any off-by-one in the divider or in the edge on which bits are taken. It also leaves the bench's converter model a spare cycle to present the next bit. A 12-cycle wait is short, yet it is long enough that a restart caused by a stray start would change the measured window.

// File: rtl/csrd_pkg.sv
package csrd_pkg;

  localparam int NUM_ADC = 2;
  localparam int WORD_W  = 18;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_GAP
  } seq_state_t;

  // Active-low select vector with only converter idx driven low.
  function automatic logic [NUM_ADC-1:0] select_lines(input logic idx);
    logic [NUM_ADC-1:0] m;
    m      = '1;
    m[idx] = 1'b0;
    return m;
  endfunction

  // Shift one sampled bit in at the LSB; MSB arrives first.
  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  // Terminal value of a counter that runs for n cycles.
  function automatic int unsigned last_of(input int unsigned n);
    return n - 1;
  endfunction

endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CYCLES = 40,
  localparam int TW    = $clog2(CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          expired,
  output logic [TW-1:0] count
);
  import csrd_pkg::*;

  logic [TW-1:0] cnt_q;

  assign expired = en && (cnt_q == TW'(last_of(CYCLES)));
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TW'(CYCLES));

  // R3
  tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/sck_gen.sv
module sck_gen #(
  parameter int DIV  = 2,
  localparam int PW  = $clog2(DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_evt
);
  import csrd_pkg::*;

  logic [PW-1:0] phase_q;
  logic          sck_q;
  logic          half_end;

  assign half_end = (phase_q == PW'(last_of(DIV)));
  // Edge on which the serial clock register goes from high to low.
  assign fall_evt = run && half_end && sck_q;
  assign sck      = sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= '0;
      sck_q   <= 1'b0;
    end else if (half_end) begin
      phase_q <= '0;
      sck_q   <= ~sck_q;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // R5
  sck_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_q);

  // R5
  sck_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_end && $past(run)) |=> $stable(sck_q));

endmodule

// File: rtl/bit_capture.sv
module bit_capture
  import csrd_pkg::*;
#(
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic              din,
  output logic [WORD_W-1:0] word_next,
  output logic              last
);

  logic [WORD_W-1:0] shreg_q;
  logic [CW-1:0]     cnt_q;

  assign word_next = push_bit(shreg_q, din);
  assign last      = sample && (cnt_q == CW'(last_of(WORD_W)));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (sample) begin
      shreg_q <= word_next;
      cnt_q   <= last ? '0 : cnt_q + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WORD_W - 1));

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clr) |=> (shreg_q[0] == $past(din)));

endmodule

// File: rtl/adc_cs_read_seq.sv
module adc_cs_read_seq
  import csrd_pkg::*;
#(
  parameter int CONV_CYCLES = 140,
  parameter int SCK_DIV     = 2,
  localparam int TW         = $clog2(CONV_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic [1:0]        cs_n_o,
  output logic [17:0]       result0_o,
  output logic [17:0]       result1_o,
  output logic              done_o
);

  seq_state_t        state_q;
  logic              dev_q;
  logic              cnv_q;
  logic              done_q;
  logic [NUM_ADC-1:0] cs_q;
  logic [WORD_W-1:0] hold0_q;
  logic [WORD_W-1:0] res0_q;
  logic [WORD_W-1:0] res1_q;

  // Named internal events
  logic              conv_launch;
  logic              wait_over;
  logic [TW-1:0]     tmr_count;
  logic              sck_run;
  logic              bit_fall;
  logic              read_last;
  logic              last_dev;
  logic [WORD_W-1:0] word_next;

  assign conv_launch = (state_q == ST_IDLE) && start_i;
  assign sck_run     = (state_q == ST_READ);
  assign last_dev    = (dev_q == 1'(NUM_ADC - 1));

  conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state_q == ST_WAIT),
    .expired (wait_over),
    .count   (tmr_count)
  );

  sck_gen #(.DIV(SCK_DIV)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sck_run),
    .sck      (sck_o),
    .fall_evt (bit_fall)
  );

  bit_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!sck_run),
    .sample    (bit_fall),
    .din       (sdo_i),
    .word_next (word_next),
    .last      (read_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dev_q   <= 1'b0;
      cnv_q   <= 1'b0;
      done_q  <= 1'b0;
      cs_q    <= '1;
      hold0_q <= '0;
      res0_q  <= '0;
      res1_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (conv_launch) begin
            cnv_q   <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_over) begin
            dev_q   <= 1'b0;
            cs_q    <= select_lines(1'b0);
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (read_last) begin
            cs_q <= '1;
            if (!last_dev) begin
              hold0_q <= word_next;
              state_q <= ST_GAP;
            end else begin
              res0_q  <= hold0_q;
              res1_q  <= word_next;
              done_q  <= 1'b1;
              cnv_q   <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          dev_q   <= 1'b1;
          cs_q    <= select_lines(1'b1);
          state_q <= ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o     = cnv_q;
  assign cs_n_o    = cs_q;
  assign done_o    = done_q;
  assign result0_o = res0_q;
  assign result1_o = res1_q;

  // R4
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_q));

  // R2
  cnv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_q) |-> cnv_q);

  // R2
  cnv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_q) |-> (&cs_q));

  // R3
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && $past(state_q) == ST_WAIT) |->
      ($past(tmr_count) == TW'(CONV_CYCLES - 1)));

  // R5
  sck_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !(&cs_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(cnv_q));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && start_i && !read_last) |=> (state_q != ST_WAIT));

endmodule

// File: tb/sim_adc_cs_read_seq.sv
`timescale 1ns/1ps
module sim_adc_cs_read_seq;

  localparam int CONV_C = 12;
  localparam int DIV    = 2;
  localparam int NV     = 6;

  // {word for converter 0, word for converter 1}
  localparam logic [35:0] VECS [0:NV-1] = '{
    {18'h3FFFF, 18'h00000},
    {18'h2AAAA, 18'h15555},
    {18'h00001, 18'h20000},
    {18'h12345, 18'h3ABCD},
    {18'h20001, 18'h1FFFE},
    {18'h00000, 18'h3FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sdo;
  logic        cnv, sck, done;
  logic [1:0]  cs_n;
  logic [17:0] r0, r1;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  adc_cs_read_seq #(.CONV_CYCLES(CONV_C), .SCK_DIV(DIV)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .sdo_i     (sdo),
    .cnv_o     (cnv),
    .sck_o     (sck),
    .cs_n_o    (cs_n),
    .result0_o (r0),
    .result1_o (r1),
    .done_o    (done)
  );

  // Converter models: MSB shown on select, next bit after each falling edge.
  logic [17:0] dev_w0 = '0, dev_w1 = '0;
  int idx0 = 0, idx1 = 0;
  logic sck_d;
  always @(posedge clk) begin
    sck_d <= sck;
    if (cs_n[0]) idx0 <= 0; else if (sck_d && !sck) idx0 <= idx0 + 1;
    if (cs_n[1]) idx1 <= 0; else if (sck_d && !sck) idx1 <= idx1 + 1;
  end
  assign sdo = (!cs_n[0] && idx0 < 18) ? dev_w0[17-idx0] :
               (!cs_n[1] && idx1 < 18) ? dev_w1[17-idx1] : 1'b0;

  // Monitor
  logic mon_clr = 1'b0;
  int falls0, falls1, wait_cnt, hcnt, hbad, done_cnt, dwide, overlap, cnv_gap, order_bad;
  bit sel_seen;
  logic sck_p, done_p;
  logic [1:0] cs_p;
  always @(negedge clk) begin
    if (mon_clr) begin
      falls0 = 0; falls1 = 0; wait_cnt = 0; hcnt = 0; hbad = 0;
      done_cnt = 0; dwide = 0; overlap = 0; cnv_gap = 0; order_bad = 0;
      sel_seen = 0;
    end else begin
      if (sck_p === 1'b1 && sck === 1'b0) begin
        if (!cs_p[0]) falls0++;
        else if (!cs_p[1]) falls1++;
        if (hcnt != DIV) hbad++;
        hcnt = 0;
      end
      if (sck === 1'b1) hcnt++;
      if (cnv && (&cs_n) && !sel_seen) wait_cnt++;
      if (!(&cs_n)) sel_seen = 1;
      if (cs_n === 2'b00) overlap++;
      if (!cs_n[1] && falls0 != 18) order_bad++;
      if (!(&cs_n) && !cnv) cnv_gap++;
      if (done) done_cnt++;
      if (done && done_p) dwide++;
    end
    sck_p  = sck;
    cs_p   = cs_n;
    done_p = done;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic begin_run(input logic [17:0] w0, input logic [17:0] w1);
    dev_w0  = w0;
    dev_w1  = w1;
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cnv", cnv, 0);
    chk("R1", "cs_n", cs_n, 2'b11);
    chk("R1", "sck", sck, 0);
    chk("R1", "done", done, 0);
    chk("R1", "results", {r0, r1}, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "cnv after release", cnv, 0);

    for (int v = 0; v < NV; v++) begin
      begin_run(VECS[v][35:18], VECS[v][17:0]);
      chk("R2", "cnv raised", cnv, 1);
      chk("R2", "cs_n high at launch", cs_n, 2'b11);
      wait_done();
      chk("R7", "done seen", done, 1);
      chk("R6", "result0", r0, VECS[v][35:18]);
      chk("R6", "result1", r1, VECS[v][17:0]);
      chk("R7", "cnv low at done", cnv, 0);
      repeat (3) @(negedge clk);
      chk("R7", "done width", dwide, 0);
      chk("R7", "done count", done_cnt, 1);
      chk("R3", "wait cycles", wait_cnt, CONV_C);
      chk("R5", "falls dev0", falls0, 18);
      chk("R5", "falls dev1", falls1, 18);
      chk("R5", "half period", hbad, 0);
      chk("R4", "overlap", overlap, 0);
      chk("R4", "order", order_bad, 0);
      chk("R2", "cnv during select", cnv_gap, 0);
      chk("R7", "results hold", {r0, r1}, VECS[v]);
    end

    // R8: starts during wait and during read are ignored
    begin_run(18'h0F0F0, 18'h30303);
    repeat (4) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk);
    #1 start = 1'b0;
    for (int i = 0; i < 200 && (&cs_n); i++) @(negedge clk);
    chk("R7", "results held before done", r0, VECS[NV-1][35:18]);
    repeat (10) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk);
    #1 start = 1'b0;
    wait_done();
    chk("R8", "result0 busy start", r0, 18'h0F0F0);
    chk("R8", "result1 busy start", r1, 18'h30303);
    repeat (60) @(negedge clk);
    chk("R8", "wait not restarted", wait_cnt, CONV_C);
    chk("R8", "single done", done_cnt, 1);
    chk("R8", "cnv stays low", cnv, 0);
    chk("R8", "selects idle", cs_n, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule